// File: doc/BRIEF.md
# BCH Syndrome Expander

This block turns the packed remainder left behind by a BCH parity engine into the full set of 2t syndromes over GF(2^13), ready for a downstream error-locator solver. The remainder arrives as a 13-byte array together with a strength select: 4 correctable bits or 8. On a start pulse the array is captured. The block then walks a mode-dependent bit window one bit per cycle, beginning at the highest position. It accumulates the odd-indexed syndromes against running powers of alpha.

Once the walk is over, the remaining syndromes are produced by squaring earlier ones, one per cycle, in increasing order. A one-cycle done pulse follows. The sixteen syndrome registers then hold their values until the next start.

Top module: `bch_syndrome_expander`

## Requirements
- R1: Field arithmetic is GF(2^13) with x^13 = x^4 + x^3 + x + 1 (overflow folds in 0x001B). At done, register i (for i < 2t) equals the sum over the scanned bits b_j (j = 0 for the first bit scanned) of b_j * alpha^((i+1)*j), where alpha = 0x0002.
- R2: Array byte n occupies rem_i[8n+7:8n]. Scan position p reads byte p/8 at bit 7 - (p mod 8).
- R3: With t8_sel_i = 0 (t = 4), positions 55 down to 4 are scanned. Bits at positions 0..3 and 56..103 have no effect on any syndrome.
- R4: With t8_sel_i = 1 (t = 8), positions 103 down to 0 are scanned.
- R5: For k < t, register 2k+1 equals the field square of register k.
- R6: Registers at index 2t and above read zero at done.
- R7: A start pulse clears every syndrome register at that edge and abandons any run in progress. The new run uses the array and select present with the pulse.
- R8: done_o is high for exactly one cycle, N + t clock edges after the start edge. N is 52 for t = 4 and 104 for t = 8, so the delays are 56 and 112.
- R9: Synchronous reset leaves every syndrome register at zero and done_o low.
- R10: After done, the syndrome outputs stay unchanged until the next start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Capture array and select, clear syndromes, begin a run |
| t8_sel_i | input | 1 | 0 selects t = 4, 1 selects t = 8 |
| rem_i | input | 104 | Packed remainder array, byte n at bits 8n+7:8n |
| syn_o | output | 208 | Syndrome register i at bits 13i+12:13i |
| done_o | output | 1 | One-cycle pulse when all 2t syndromes are valid |

## Verification
The bench builds the block with the package defaults: a 13-byte array, a 13-bit field and a strength of up to 8. These sizes are small enough that every scanned position of both windows can be driven as a lone set bit. The expected syndromes for each run are obtained by direct power-sum evaluation with a general field multiplier. The defaults also let the bench fill only the bits outside the 4-bit window and confirm that they are ignored. They also keep pseudo-random full arrays, a restart in the middle of a run and the exact done latency of each mode inside a short run.

// File: rtl/bch_syn_pkg.sv
package bch_syn_pkg;

    localparam int GF_M     = 13;
    localparam logic [GF_M-1:0] GF_TAIL = 13'h001B;
    localparam int NBYTES   = 13;
    localparam int NBITS    = NBYTES * 8;
    localparam int T_MAX    = 8;
    localparam int T_MIN    = T_MAX / 2;
    localparam int NSYN     = 2 * T_MAX;
    localparam int POS_W    = $clog2(NBITS);
    localparam int SQ_W     = $clog2(T_MAX);
    localparam int SMALL_LO = 4;
    localparam int SMALL_HI = SMALL_LO + T_MIN * GF_M - 1;
    localparam int BIG_LO   = 0;
    localparam int BIG_HI   = NBITS - 1;

    typedef logic [GF_M-1:0] gf_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_SCAN = 2'd1,
        PH_SQR  = 2'd2
    } phase_e;

    typedef enum logic {
        CAP_T4 = 1'b0,
        CAP_T8 = 1'b1
    } cap_e;

    typedef struct packed {
        phase_e           phase;
        cap_e             cap;
        logic [POS_W-1:0] pos;
        logic             lead;
        logic [SQ_W-1:0]  sq_idx;
    } ctl_s;

    // multiply by x with reduction
    function automatic gf_t gf_xtime(gf_t a);
        return {a[GF_M-2:0], 1'b0} ^ (a[GF_M-1] ? GF_TAIL : '0);
    endfunction

    // multiply by x^n, n < NSYN
    function automatic gf_t gf_xpow(gf_t a, int n);
        gf_t r;
        r = a;
        for (int i = 0; i < NSYN; i++) begin
            if (i < n) r = gf_xtime(r);
        end
        return r;
    endfunction

    function automatic gf_t gf_mul(gf_t a, gf_t b);
        gf_t r;
        r = '0;
        for (int i = GF_M - 1; i >= 0; i--) begin
            r = gf_xtime(r);
            if (a[i]) r = r ^ b;
        end
        return r;
    endfunction

    function automatic gf_t alpha_pow(int e);
        return gf_xpow(gf_t'(1), e);
    endfunction

endpackage

// File: rtl/bch_syn_bit_tap.sv
module bch_syn_bit_tap
    import bch_syn_pkg::*;
(
    input  logic [NBITS-1:0] bytes_i,
    input  logic [POS_W-1:0] pos_i,
    output logic             bit_o
);
    // byte p/8, bit 7-(p mod 8): flip the low three index bits
    logic [POS_W-1:0] idx;
    assign idx   = pos_i ^ POS_W'(7);
    assign bit_o = bytes_i[idx];
endmodule

// File: rtl/bch_syn_pow_lane.sv
module bch_syn_pow_lane
    import bch_syn_pkg::*;
#(
    parameter int EXP = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic load_i,
    input  logic adv_i,
    output gf_t  pow_o
);
    localparam gf_t SEED = alpha_pow(EXP);

    gf_t pow_q;

    always_ff @(posedge clk) begin
        if (rst || load_i) pow_q <= SEED;
        else if (adv_i)    pow_q <= gf_xpow(pow_q, EXP);
    end

    assign pow_o = pow_q;
endmodule

// File: rtl/bch_syn_square.sv
module bch_syn_square
    import bch_syn_pkg::*;
(
    input  gf_t a_i,
    output gf_t sq_o
);
    assign sq_o = gf_mul(a_i, a_i);
endmodule

// File: rtl/bch_syndrome_expander.sv
module bch_syndrome_expander
    import bch_syn_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start_i,
    input  logic                   t8_sel_i,
    input  logic [NBITS-1:0]       rem_i,
    output logic [NSYN*GF_M-1:0]   syn_o,
    output logic                   done_o
);
    ctl_s             ctl_q;
    gf_t              syn_q [NSYN];
    logic [NBITS-1:0] rem_q;
    logic             done_q;
    logic             tap_bit;
    gf_t              pow_w [T_MAX];
    gf_t              sq_in, sq_out;
    int               t_cur;
    logic [POS_W-1:0] pos_lo;
    logic             lane_adv;

    assign t_cur    = (ctl_q.cap == CAP_T8) ? T_MAX : T_MIN;
    assign pos_lo   = (ctl_q.cap == CAP_T8) ? POS_W'(BIG_LO) : POS_W'(SMALL_LO);
    assign lane_adv = (ctl_q.phase == PH_SCAN) && !ctl_q.lead;

    bch_syn_bit_tap u_tap (
        .bytes_i (rem_q),
        .pos_i   (ctl_q.pos),
        .bit_o   (tap_bit)
    );

    for (genvar k = 0; k < T_MAX; k++) begin : g_lane
        bch_syn_pow_lane #(.EXP(2*k + 1)) u_lane (
            .clk    (clk),
            .rst    (rst),
            .load_i (start_i),
            .adv_i  (lane_adv),
            .pow_o  (pow_w[k])
        );
    end

    always_comb begin
        sq_in = '0;
        for (int k = 0; k < T_MAX; k++) begin
            if (ctl_q.sq_idx == SQ_W'(k)) sq_in = syn_q[k];
        end
    end

    bch_syn_square u_sq (
        .a_i  (sq_in),
        .sq_o (sq_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= '{phase: PH_IDLE, cap: CAP_T4, pos: '0, lead: 1'b0, sq_idx: '0};
            syn_q  <= '{default: '0};
            rem_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start_i) begin
                ctl_q.phase  <= PH_SCAN;
                ctl_q.cap    <= t8_sel_i ? CAP_T8 : CAP_T4;
                ctl_q.pos    <= t8_sel_i ? POS_W'(BIG_HI) : POS_W'(SMALL_HI);
                ctl_q.lead   <= 1'b1;
                ctl_q.sq_idx <= '0;
                syn_q        <= '{default: '0};
                rem_q        <= rem_i;
            end else begin
                case (ctl_q.phase)
                    PH_SCAN: begin
                        for (int k = 0; k < T_MAX; k++) begin
                            if (k < t_cur) begin
                                if (ctl_q.lead)
                                    syn_q[2*k] <= {{(GF_M-1){1'b0}}, tap_bit};
                                else if (tap_bit)
                                    syn_q[2*k] <= syn_q[2*k] ^ pow_w[k];
                            end
                        end
                        ctl_q.lead <= 1'b0;
                        if (ctl_q.pos == pos_lo) begin
                            ctl_q.phase  <= PH_SQR;
                            ctl_q.sq_idx <= '0;
                        end else begin
                            ctl_q.pos <= ctl_q.pos - POS_W'(1);
                        end
                    end
                    PH_SQR: begin
                        for (int k = 0; k < T_MAX; k++) begin
                            if (ctl_q.sq_idx == SQ_W'(k)) syn_q[2*k + 1] <= sq_out;
                        end
                        if (ctl_q.sq_idx == SQ_W'(t_cur - 1)) begin
                            ctl_q.phase <= PH_IDLE;
                            done_q      <= 1'b1;
                        end else begin
                            ctl_q.sq_idx <= ctl_q.sq_idx + SQ_W'(1);
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    for (genvar i = 0; i < NSYN; i++) begin : g_out
        assign syn_o[GF_M*i +: GF_M] = syn_q[i];
    end

    assign done_o = done_q;
endmodule

// File: rtl/bch_syn_chk.sv
module bch_syn_chk
    import bch_syn_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 start_i,
    input logic                 done_o,
    input logic [NSYN*GF_M-1:0] syn_o,
    input phase_e               phase,
    input cap_e                 cap
);
    // R8: done is a single-cycle pulse
    p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R8: done only follows the squaring phase
    p_done_after_sqr_r8: assert property (@(posedge clk) disable iff (rst)
        done_o |-> ($past(phase) == PH_SQR));

    // R7: start clears all syndromes
    p_start_clears_r7: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (syn_o == '0));

    // R6: upper half stays zero in the 4-bit mode
    p_upper_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (cap == CAP_T4) |-> (syn_o[NSYN*GF_M-1 : T_MAX*GF_M] == '0));

    // R10: idle without start holds the results
    p_hold_idle_r10: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE && !start_i) |=> $stable(syn_o));

    // R9: reset clears outputs
    p_reset_clear_r9: assert property (@(posedge clk)
        rst |=> (!done_o && syn_o == '0));
endmodule

bind bch_syndrome_expander bch_syn_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .done_o  (done_o),
    .syn_o   (syn_o),
    .phase   (ctl_q.phase),
    .cap     (ctl_q.cap)
);

// File: tb/sim_bch_syndrome_expander.sv
module sim_bch_syndrome_expander;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic         t8 = 1'b0;
    logic [103:0] rem = '0;
    logic [207:0] syn;
    logic         done;

    int n_tot = 0;
    int n_pass = 0;
    logic [12:0] exp_syn [16];
    logic [31:0] rng = 32'h1234_5678;

    always #4 clk = ~clk;

    bch_syndrome_expander u0 (
        .clk(clk), .rst(rst), .start_i(start), .t8_sel_i(t8),
        .rem_i(rem), .syn_o(syn), .done_o(done)
    );

    function automatic logic [12:0] gmul(logic [12:0] a, logic [12:0] b);
        logic [12:0] r = '0;
        for (int i = 12; i >= 0; i--) begin
            r = {r[11:0], 1'b0} ^ (r[12] ? 13'h001B : 13'h0);
            if (a[i]) r = r ^ b;
        end
        return r;
    endfunction

    function automatic logic [12:0] syn_at(int i);
        return syn[13*i +: 13];
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        n_tot++;
        if (ok) n_pass++;
        else $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    endtask

    // direct power-sum evaluation over the scanned window
    task automatic ref_calc(input logic [103:0] d, input logic sel8);
        int t, hi, n, p;
        logic [12:0] base, term, acc;
        t  = sel8 ? 8 : 4;
        hi = sel8 ? 103 : 55;
        n  = sel8 ? 104 : 52;
        for (int i = 0; i < 16; i++) exp_syn[i] = '0;
        for (int i = 0; i < 2*t; i++) begin
            base = 13'h1;
            for (int e = 0; e <= i; e++) base = gmul(base, 13'h2);
            term = 13'h1;
            acc  = '0;
            for (int j = 0; j < n; j++) begin
                p = hi - j;
                if (d[8*(p/8) + 7 - (p%8)]) acc = acc ^ term;
                term = gmul(term, base);
            end
            exp_syn[i] = acc;
        end
    endtask

    task automatic run(input logic [103:0] d, input logic sel8, input string req);
        int cnt, lat;
        ref_calc(d, sel8);
        lat = sel8 ? 112 : 56;
        @(negedge clk);
        rem = d; t8 = sel8; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        chk(syn == '0, "R7", "cleared after start", syn[31:0], 32'h0);
        cnt = 0;
        while (1) begin
            @(posedge clk);
            cnt++;
            @(negedge clk);
            if (done || cnt > 400) break;
        end
        chk(cnt == lat, "R8", "done latency", cnt, lat);
        for (int i = 0; i < 16; i++)
            chk(syn_at(i) == exp_syn[i], (i >= (sel8 ? 16 : 8)) ? "R6" : req,
                $sformatf("syndrome %0d", i), syn_at(i), exp_syn[i]);
        for (int k = 0; k < (sel8 ? 8 : 4); k++)
            chk(syn_at(2*k+1) == gmul(syn_at(k), syn_at(k)), "R5",
                $sformatf("square %0d", k), syn_at(2*k+1), gmul(syn_at(k), syn_at(k)));
        @(negedge clk);
        chk(done == 1'b0, "R8", "done one cycle", done, 0);
        repeat (3) @(negedge clk);
        for (int i = 0; i < 16; i++)
            chk(syn_at(i) == exp_syn[i], "R10", $sformatf("hold %0d", i), syn_at(i), exp_syn[i]);
    endtask

    function automatic logic [31:0] nxt(logic [31:0] s);
        logic [31:0] x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    initial begin
        #(8 * 190000);
        n_tot++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", n_pass, n_tot);
        $finish;
    end

    initial begin
        logic [103:0] d, da, db;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(syn == '0, "R9", "syndromes at reset", syn[31:0], 0);
        chk(done == 1'b0, "R9", "done at reset", done, 0);
        rst = 1'b0;

        run('0, 1'b0, "R1");
        run('0, 1'b1, "R1");
        // R4: each position of the wide window alone
        for (int p = 0; p < 104; p++) begin
            d = '0; d[8*(p/8) + 7 - (p%8)] = 1'b1;
            run(d, 1'b1, "R2");
        end
        // R3: each position of the narrow window alone
        for (int p = 4; p < 56; p++) begin
            d = '0; d[8*(p/8) + 7 - (p%8)] = 1'b1;
            run(d, 1'b0, "R3");
        end
        // R3: only out-of-window bits set -> all zero
        d = '0;
        for (int p = 0; p < 104; p++)
            if (p < 4 || p > 55) d[8*(p/8) + 7 - (p%8)] = 1'b1;
        run(d, 1'b0, "R3");
        // R1/R4: pseudo-random arrays in both modes, wide after narrow and back
        for (int r = 0; r < 16; r++) begin
            for (int w = 0; w < 4; w++) begin
                rng = nxt(rng);
                d[32*w +: 8] = rng[7:0];
                if (w < 3) d[32*w +: 32] = rng;
            end
            run(d, r[0], r[0] ? "R4" : "R1");
        end
        run({104{1'b1}}, 1'b1, "R4");
        run({104{1'b1}}, 1'b0, "R3");
        // R7: restart in the middle of a wide run
        rng = nxt(rng); da = {rng, rng, rng, rng[7:0]};
        rng = nxt(rng); db = {rng[7:0], rng, ~rng, rng};
        @(negedge clk);
        rem = da; t8 = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (30) @(negedge clk);
        run(db, 1'b0, "R7");

        $display("%0d/%0d checks passed", n_pass, n_tot);
        $finish;
    end
endmodule